// File: doc/BRIEF.md
# Integration-Time Measurement Sequencer

This block decides when a light-measurement conversion window runs and when the five 16-bit result registers take new values. It is driven by a configuration word. One field sets the window length in millisecond ticks. The other fields choose the dynamic setting, power the block down, switch between free-running and on-demand operation, and trigger a single on-demand measurement. The time base is a one-cycle `ms_tick` input, so a window is counted in ticks and not in clock cycles.

In free-running mode the windows follow each other with no gap. In on-demand mode a trigger write starts exactly one window, and the trigger field then reads back as zero again. At the end of a window the block captures five channel values into its result registers. The values come either from a built-in stub accumulator or from test inputs. The results then stay as they are, through shutdown and wake-up, until another window completes. Each capture is marked by a one-cycle `done` pulse.

Top module: `uv_window_sequencer`

## Requirements
- R1: While reset is held, `cfg_rdata`, `results`, `busy` and `done` are all zero. The configuration resets to 0, which selects powered-on free-running mode with the shortest window.
- R2: `cfg_rdata[6:4]` reads back the window code as written, bit 3 the dynamic setting, bit 1 the on-demand enable and bit 0 shutdown. Bit 7 and bits 15:8 always read 0.
- R3: Window code 0..4 in bits 6:4 gives 50, 100, 200, 400 or 800 ticks (`BASE_TICKS` shifted left by the code). Codes 5, 6 and 7 give 800 ticks. The code and the dynamic bit are captured when a window begins. With a tick on every cycle, `done` is seen exactly length+1 cycles after the clock edge that takes a starting configuration write.
- R4: The window advances only on cycles with `ms_tick` high. Cycles without a tick lengthen the window in clock cycles but not in ticks.
- R5: With `src_sel`=0, channel k (0..4, held at `results[16k+15:16k]`) captures ticks×(k+1). With the dynamic bit set, it captures that value shifted right by one.
- R6: With `src_sel`=1, channel k captures `test_vals[16k+15:16k]` as present on the last tick of the window.
- R7: A write with bit 2=1, bit 1=1 and bit 0=0 while no window runs starts exactly one window. Bit 2 reads 1 for the single cycle after that write and 0 afterwards. No further window follows.
- R8: A trigger write made while a window is running is ignored. Bit 2 reads 0 after it, and the running window keeps its captured length and produces a single capture.
- R9: In free-running mode the next window begins on the same edge that captures the results, so consecutive `done` pulses are exactly one window length in ticks apart.
- R10: A write with bit 0=1 aborts a running window at once. `busy` falls, and neither `done` nor a capture follows.
- R11: The results change only together with `done`. They are held through shutdown and after wake-up until a new window completes.
- R12: `done` is a one-cycle pulse, raised on the same edge that loads the result registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ms_tick | input | 1 | One-cycle millisecond time-base pulse |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_rdata | output | 16 | Configuration readback |
| src_sel | input | 1 | 0: stub accumulator, 1: test inputs |
| test_vals | input | 80 | Five 16-bit test channel values, channel k at bits 16k+15:16k |
| results | output | 80 | Five 16-bit result registers, channel k at bits 16k+15:16k |
| busy | output | 1 | A window is running |
| done | output | 1 | One-cycle pulse when results are captured |

## Verification
A configuration write is taken at edge E0. The window begins at E1, and with a tick on every cycle the capture and `done` come on edge E(length+1). The bench therefore measures, from the negative edge after E0, the number of negative edges until `done` is seen, and compares that count with length+1. In free-running mode it compares the gap between pulses with the length alone. The trigger readback is sampled one and two negative edges after the write, to see the bit at 1 and then back at 0. Results and `busy` are read at the negative edge following `done`, an abort or a reset. Hold and ignore cases are observed at the ports over a span longer than the window.

// File: rtl/uv_window_sequencer.sv
module uv_window_sequencer #(
  parameter int CH_W       = 16,
  parameter int NUM_CH     = 5,
  parameter int BASE_TICKS = 50
)(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ms_tick,
  input  logic                     cfg_we,
  input  logic [15:0]              cfg_wdata,
  output logic [15:0]              cfg_rdata,
  input  logic                     src_sel,
  input  logic [NUM_CH*CH_W-1:0]   test_vals,
  output logic [NUM_CH*CH_W-1:0]   results,
  output logic                     busy,
  output logic                     done
);
  localparam int MAX_TICKS = BASE_TICKS * 16;
  localparam int CW        = $clog2(MAX_TICKS + 1);

  logic [2:0]    it_q;
  logic          hd_q, af_q, sd_q, trig_q;
  logic          run_hd;
  logic [CW-1:0] cnt, run_len;
  logic [CH_W-1:0] acc   [NUM_CH];
  logic [CH_W-1:0] nxt   [NUM_CH];
  logic [CH_W-1:0] res_q [NUM_CH];

  function automatic logic [CW-1:0] len_of(input logic [2:0] code);
    logic [CW-1:0] b;
    b = CW'(BASE_TICKS);
    return (code > 3'd4) ? (b << 4) : (b << code);
  endfunction

  wire abort     = cfg_we & cfg_wdata[0];
  wire trig_ok   = cfg_we & cfg_wdata[2] & cfg_wdata[1] & ~cfg_wdata[0] & ~busy;
  wire start     = ~busy & ~sd_q & (trig_q | ~af_q);
  wire last      = busy & ms_tick & (cnt == run_len - 1'b1);
  wire latch     = last & ~abort;
  wire begin_win = ~abort & (start | (last & ~af_q));

  assign cfg_rdata = {9'd0, it_q, hd_q, trig_q, af_q, sd_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {it_q, hd_q, af_q, sd_q, trig_q} <= '0;
    end else begin
      trig_q <= trig_ok;
      if (cfg_we) begin
        it_q <= cfg_wdata[6:4];
        hd_q <= cfg_wdata[3];
        af_q <= cfg_wdata[1];
        sd_q <= cfg_wdata[0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      cnt     <= '0;
      run_len <= '0;
      run_hd  <= 1'b0;
    end else begin
      done <= latch;
      if (abort) begin
        busy <= 1'b0;
      end else if (begin_win) begin
        busy    <= 1'b1;
        cnt     <= '0;
        run_len <= len_of(it_q);
        run_hd  <= hd_q;
      end else if (last) begin
        busy <= 1'b0;
      end else if (busy & ms_tick) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  always_comb
    for (int k = 0; k < NUM_CH; k++) nxt[k] = acc[k] + CH_W'(k + 1);

  always_ff @(posedge clk) begin
    for (int k = 0; k < NUM_CH; k++) begin
      if (!rst_n) begin
        acc[k]   <= '0;
        res_q[k] <= '0;
      end else begin
        if (begin_win)           acc[k] <= '0;
        else if (busy & ms_tick) acc[k] <= nxt[k];
        if (latch)
          res_q[k] <= src_sel ? test_vals[k*CH_W +: CH_W]
                              : (run_hd ? (nxt[k] >> 1) : nxt[k]);
      end
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_out
    assign results[g*CH_W +: CH_W] = res_q[g];
  end

  // R12: capture marker lasts one cycle
  a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R11: results move only with done
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(results));
  // R10: shutdown write aborts without capture
  a_r10_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_wdata[0]) |=> (!busy && !done));
  // R7: trigger field clears itself
  a_r7_trig_clear: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[2] |=> !cfg_rdata[2]);
  // R8: trigger during a window is dropped
  a_r8_trig_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cfg_we && cfg_wdata[2]) |=> !cfg_rdata[2]);
  // R3: a capture ends a running window
  a_r3_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy));
endmodule

// File: tb/uv_window_sequencer_bench.sv
module uv_window_sequencer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ms_tick = 1'b1;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic        src_sel = 1'b0;
  logic [79:0] test_vals = '0;
  logic [79:0] results;
  logic        busy, done;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  uv_window_sequencer u_uv_window_sequencer (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .src_sel(src_sel),
    .test_vals(test_vals), .results(results), .busy(busy), .done(done)
  );

  // {cfg byte, src_sel, expected window ticks}
  localparam logic [19:0] VEC [7] = '{
    {8'h06, 1'b0, 11'd50},
    {8'h1E, 1'b0, 11'd100},
    {8'h26, 1'b0, 11'd200},
    {8'h56, 1'b0, 11'd800},
    {8'h36, 1'b1, 11'd400},
    {8'h7E, 1'b0, 11'd800},
    {8'h46, 1'b0, 11'd800}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic wait_done(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!done && n < 5000);
    if (n >= 5000) begin
      checks++; fails++;
      $display("FAIL R3 timeout actual=%0d expected=done", n);
    end
  endtask

  task automatic count_dones(input int cyc, output int c);
    c = 0;
    for (int i = 0; i < cyc; i++) begin @(negedge clk); if (done) c++; end
  endtask

  initial begin
    #(8 * 150000);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int n, c;
    logic [15:0] saved;
    repeat (3) @(negedge clk);
    check("R1 cfg_rdata", cfg_rdata, 0);
    check("R1 results", results[31:0], 0);
    check("R1 busy/done", {busy, done}, 0);
    rst_n = 1'b1;

    wr(16'h0001);
    check("R10 busy after shutdown", busy, 0);

    for (int i = 0; i < 7; i++) begin
      logic [7:0] cb;
      int len;
      cb = VEC[i][19:12];
      len = int'(VEC[i][10:0]);
      src_sel = VEC[i][11];
      for (int k = 0; k < 5; k++) test_vals[k*16 +: 16] = 16'hA000 + 16'(i*16 + k);
      wr({8'h00, cb});
      wait_done(n);
      check("R3 latency", n, len + 1);
      for (int k = 0; k < 5; k++) begin
        int ex;
        ex = VEC[i][11] ? (32'hA000 + i*16 + k) : ((len * (k + 1)) >> cb[3]);
        check(VEC[i][11] ? "R6 test capture" : "R5 stub value", results[k*16 +: 16], ex);
      end
      @(negedge clk);
      check("R12 done one cycle", done, 0);
      check("R7 idle after one window", busy, 0);
    end
    src_sel = 1'b0;

    wr(16'hFFFF);
    check("R2 readback reserved zero", cfg_rdata, 16'h007B);

    wr(16'h0001);
    wr(16'h0006);
    check("R7 trigger bit set", cfg_rdata[2], 1);
    @(negedge clk);
    check("R7 trigger bit cleared", cfg_rdata[2], 0);
    check("R7 running", busy, 1);
    wait_done(n);
    count_dones(120, c);
    check("R7 single window", c, 0);

    wr(16'h0001);
    wr(16'h0016);
    repeat (20) @(negedge clk);
    wr(16'h0006);
    check("R8 trigger ignored readback", cfg_rdata[2], 0);
    wait_done(n);
    check("R8 length kept", results[15:0], 100);
    count_dones(150, c);
    check("R8 no second window", c, 0);

    wr(16'h0001);
    ms_tick = 1'b0;
    wr(16'h0006);
    repeat (30) @(negedge clk);
    check("R4 paused busy", busy, 1);
    ms_tick = 1'b1;
    wait_done(n);
    check("R4 ticks counted", n, 50);
    check("R4 value", results[15:0], 50);

    wr(16'h0001);
    wr(16'h0000);
    wait_done(n);
    check("R9 first window", n, 51);
    wait_done(n);
    check("R9 back to back", n, 50);
    check("R5 channel 1", results[31:16], 100);

    repeat (20) @(negedge clk);
    saved = results[15:0];
    wr(16'h0001);
    check("R10 abort busy", busy, 0);
    count_dones(100, c);
    check("R10 no capture", c, 0);
    check("R11 held in shutdown", results[15:0], saved);
    wr(16'h0010);
    repeat (50) @(negedge clk);
    check("R11 held after wake", results[15:0], saved);
    wait_done(n);
    check("R11 new result", results[15:0], 100);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule